// File: doc/BRIEF.md
# Rotating-Priority Request Encoder with Active Count

This block looks at a vector of request lines and names one winner among them. The priority order is not fixed. A runtime floor selector names the request line that has the lowest priority. The line just above it, circularly, has the highest priority, and priority falls from there in rising index order, wrapping from the top line back to line 0. A controller that moves the selector after each grant gets a round-robin style ordering. The arbitration state that drives that movement stays outside this block.

The block returns three results:
- the original, un-rotated index of the winning line;
- a flag that is high when any line is requesting;
- the number of lines that are requesting.

The decision logic is purely combinational. Two equivalent structures are available through a parameter:
- rotate the request vector, encode it with one fixed encoder, then map the result back to the original position;
- use a bank of fixed encoders, one for each selector value, and choose among their results by the selector.

A parameter can also place a register stage on the outputs for timing. With the register stage, which is the default, the results appear one clock after the inputs are sampled.

Top module: `rot_prio_encoder`

## Requirements
- R1: `any_req_o` is 1 exactly when at least one bit of the sampled request vector is 1.
- R2: `req_count_o` equals the number of 1 bits in the sampled request vector, from 0 up to 8, as an unsigned 4-bit value.
- R3: `grant_idx_o` is the first set request position found by scanning positions (sel+1) mod 8, (sel+2) mod 8, and so on up to sel, where sel is the sampled `floor_sel_i`. This holds for all 256 request patterns under every one of the 8 selector values.
- R4: The line whose index equals `floor_sel_i` wins only when it is the only active request. If any other line is active, that other line wins.
- R5: When no request is active, `any_req_o` is 0, `req_count_o` is 0 and `grant_idx_o` is 0.
- R6: With the default output register, the outputs reflect the inputs sampled at the previous rising edge of `clk`. A rising edge with `rst_n` low forces all outputs to 0 at that edge.
- R7: When all 8 requests are active, `grant_idx_o` is (sel+1) mod 8 and `req_count_o` is 8.
- R8: Whenever `any_req_o` is 1, the request bit at position `grant_idx_o` of the sampled vector is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| req_i | input | 8 | Request lines, bit k is line k |
| floor_sel_i | input | 3 | Index of the lowest-priority line |
| grant_idx_o | output | 3 | Original index of the winning line, 0 when idle |
| any_req_o | output | 1 | High when at least one line requests |
| req_count_o | output | 4 | Number of active request lines |

## Verification
The winner selection and the population count are computed in the same cycle from the same sampled vector. The dense patterns are the ones that stress both at once. The all-ones vector under each selector must give the wrap-around winner together with the maximum count of 8. The exhaustive sweep applies every vector under every selector and judges the index, the flag and the count on every vector against a scan model and a bit tally kept in the bench. A reset asserted while all lines are requesting must clear the index and the count together, even though both would otherwise be non-zero.

// File: rtl/ppe_pkg.sv
// Shared definitions for the rotating-priority request encoder.
// Assumes the request count is a power of two or that callers keep
// every operand of wrap_sum below the modulus.
package ppe_pkg;

    // Selects which combinational structure produces the winner index.
    typedef enum logic [0:0] {
        ARCH_ROTATE = 1'b0,  // one rotator, one fixed encoder, one re-map
        ARCH_BANK   = 1'b1   // one fixed encoder per selector value, then a mux
    } arch_e;

    // Circular sum of two positions on a ring of n entries.
    function automatic int wrap_sum(input int a, input int b, input int n);
        return (a + b) % n;
    endfunction

endpackage

// File: rtl/ppe_rotate.sv
// Circular rotator: output bit k takes input bit (k + amt_i) mod N.
// Assumes amt_i < N. Purely combinational.
module ppe_rotate #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    input  logic [W-1:0] amt_i,
    output logic [N-1:0] vec_o
);

    // Route each output bit from its rotated source position.
    always_comb begin
        logic [W-1:0] src;
        vec_o = '0;
        for (int k = 0; k < N; k++) begin
            src      = W'(ppe_pkg::wrap_sum(k, int'(amt_i), N));
            vec_o[k] = vec_i[src];
        end
    end

endmodule

// File: rtl/ppe_first_set.sv
// Fixed priority encoder: reports the lowest set position of vec_i.
// Assumes nothing about the input. pos_o is 0 when no bit is set.
module ppe_first_set #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    output logic         found_o,
    output logic [W-1:0] pos_o
);

    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        pos_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (vec_i[k]) pos_o = W'(k);
        end
        found_o = |vec_i;
    end

endmodule

// File: rtl/ppe_popcount.sv
// Population count of an N-bit vector, result width CW.
// Assumes CW can hold the value N. Purely combinational.
module ppe_popcount #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);

    // Add up the set bits one at a time.
    always_comb begin
        cnt_o = '0;
        for (int k = 0; k < N; k++) begin
            cnt_o = cnt_o + CW'(vec_i[k]);
        end
    end

endmodule

// File: rtl/rot_prio_encoder.sv
// Rotating-priority request encoder with an active-request count.
// The line named by floor_sel_i has the lowest priority. Its circular
// successor has the highest. ARCH picks the decision structure, and
// OUT_REG adds one output register stage with a synchronous active-low
// reset. Assumes N_REQ is a power of two so that index arithmetic wraps.
module rot_prio_encoder #(
    parameter int             N_REQ   = 8,
    parameter ppe_pkg::arch_e ARCH    = ppe_pkg::ARCH_ROTATE,
    parameter bit             OUT_REG = 1'b1,
    localparam int            IDX_W   = $clog2(N_REQ),
    localparam int            CNT_W   = $clog2(N_REQ + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic [IDX_W-1:0] floor_sel_i,
    output logic [IDX_W-1:0] grant_idx_o,
    output logic             any_req_o,
    output logic [CNT_W-1:0] req_count_o
);

    logic [IDX_W-1:0] win_c;
    logic             any_c;
    logic [CNT_W-1:0] cnt_c;

    ppe_popcount #(.N(N_REQ), .CW(CNT_W)) u_count (
        .vec_i (req_i),
        .cnt_o (cnt_c)
    );

    generate
        if (ARCH == ppe_pkg::ARCH_ROTATE) begin : g_rotate
            logic [IDX_W-1:0] start;
            logic [N_REQ-1:0] rot_vec;
            logic [IDX_W-1:0] rot_pos;
            logic             found;

            // Highest-priority position is one past the floor.
            always_comb start = IDX_W'(ppe_pkg::wrap_sum(int'(floor_sel_i), 1, N_REQ));

            ppe_rotate #(.N(N_REQ), .W(IDX_W)) u_rot (
                .vec_i (req_i),
                .amt_i (start),
                .vec_o (rot_vec)
            );

            ppe_first_set #(.N(N_REQ), .W(IDX_W)) u_enc (
                .vec_i   (rot_vec),
                .found_o (found),
                .pos_o   (rot_pos)
            );

            // Map the rotated position back to the original line index.
            always_comb begin
                any_c = found;
                win_c = found ? IDX_W'(ppe_pkg::wrap_sum(int'(rot_pos), int'(start), N_REQ))
                              : '0;
            end
        end else begin : g_bank
            logic [IDX_W-1:0] bank_win   [N_REQ];
            logic             bank_found [N_REQ];

            for (genvar s = 0; s < N_REQ; s++) begin : g_slot
                localparam int OFS = (s + 1) % N_REQ;
                logic [N_REQ-1:0] slot_vec;
                logic [IDX_W-1:0] slot_pos;

                ppe_rotate #(.N(N_REQ), .W(IDX_W)) u_rot (
                    .vec_i (req_i),
                    .amt_i (IDX_W'(OFS)),
                    .vec_o (slot_vec)
                );

                ppe_first_set #(.N(N_REQ), .W(IDX_W)) u_enc (
                    .vec_i   (slot_vec),
                    .found_o (bank_found[s]),
                    .pos_o   (slot_pos)
                );

                // Re-map this slot's encoded position with its fixed offset.
                always_comb bank_win[s] = bank_found[s]
                    ? IDX_W'(ppe_pkg::wrap_sum(int'(slot_pos), OFS, N_REQ)) : '0;
            end

            // Pick the slot that matches the runtime floor selector.
            always_comb begin
                any_c = bank_found[floor_sel_i];
                win_c = bank_win[floor_sel_i];
            end
        end
    endgenerate

    generate
        if (OUT_REG) begin : g_reg
            // Register the results; a low rst_n at an edge clears them.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    grant_idx_o <= '0;
                    any_req_o   <= 1'b0;
                    req_count_o <= '0;
                end else begin
                    grant_idx_o <= win_c;
                    any_req_o   <= any_c;
                    req_count_o <= cnt_c;
                end
            end
        end else begin : g_comb
            // Pass the combinational results straight through.
            always_comb begin
                grant_idx_o = win_c;
                any_req_o   = any_c;
                req_count_o = cnt_c;
            end
        end
    endgenerate

endmodule

// File: rtl/rot_prio_encoder_chk.sv
// Property checker for rot_prio_encoder, attached by bind. It keeps its
// own copy of the sampled inputs and judges the registered outputs one
// edge later. Its properties apply only when OUT_REG is set.
module rot_prio_encoder_chk #(
    parameter int  N_REQ   = 8,
    parameter bit  OUT_REG = 1'b1,
    localparam int IDX_W   = $clog2(N_REQ),
    localparam int CNT_W   = $clog2(N_REQ + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] req_i,
    input logic [IDX_W-1:0] floor_sel_i,
    input logic [IDX_W-1:0] grant_idx_o,
    input logic             any_req_o,
    input logic [CNT_W-1:0] req_count_o
);

    logic [N_REQ-1:0] req_q;
    logic [IDX_W-1:0] sel_q;
    logic             live_q;

    // Capture the inputs that the design registered at the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            sel_q  <= '0;
            live_q <= 1'b0;
        end else begin
            req_q  <= req_i;
            sel_q  <= floor_sel_i;
            live_q <= 1'b1;
        end
    end

    assert_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_REG && live_q) |-> (any_req_o == (req_q != '0)));

    assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_REG && live_q) |-> (req_count_o == CNT_W'($countones(req_q))));

    assert_floor_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_REG && live_q && any_req_o && grant_idx_o == sel_q)
            |-> ($countones(req_q) == 1));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_REG && !any_req_o) |-> (grant_idx_o == '0 && req_count_o == '0));

    assert_reset_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_REG && !live_q) |-> (!any_req_o && grant_idx_o == '0 && req_count_o == '0));

    assert_winner_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_REG && live_q && any_req_o) |-> req_q[grant_idx_o]);

endmodule

bind rot_prio_encoder rot_prio_encoder_chk #(
    .N_REQ   (N_REQ),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .floor_sel_i (floor_sel_i),
    .grant_idx_o (grant_idx_o),
    .any_req_o   (any_req_o),
    .req_count_o (req_count_o)
);

// File: tb/rot_prio_encoder_test.sv
// Directed bench for rot_prio_encoder: one task per scenario, each task
// checking its own results. Inputs change on falling edges and outputs
// are read on the next falling edge, one register stage later.
module rot_prio_encoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic [2:0] sel = '0;
    logic [2:0] idx;
    logic       any;
    logic [3:0] cnt;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    rot_prio_encoder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .floor_sel_i (sel),
        .grant_idx_o (idx),
        .any_req_o   (any),
        .req_count_o (cnt)
    );

    // Reference winner: scan circularly upward from the line after the floor.
    function automatic int model_win(input int r, input int s);
        for (int k = 1; k <= 8; k++) begin
            int p = (s + k) % 8;
            if (((r >> p) & 1) != 0) return p;
        end
        return 0;
    endfunction

    // Reference tally of set bits.
    function automatic int model_cnt(input int r);
        int c = 0;
        for (int k = 0; k < 8; k++) c += (r >> k) & 1;
        return c;
    endfunction

    // Compare one value and count the outcome.
    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (req=%02h sel=%0d)",
                     tag, act, exp, req, sel);
        end
    endtask

    // Drive one input pair and wait until the registered result is visible.
    task automatic apply(input int r, input int s);
        @(negedge clk);
        req = 8'(r);
        sel = 3'(s);
        @(negedge clk);
    endtask

    // Power-up reset clears all outputs (R6, R5).
    task automatic t_reset;
        rst_n = 1'b0;
        req = 8'hA5;
        sel = 3'd2;
        repeat (2) @(negedge clk);
        check("R6 reset idx", int'(idx), 0);
        check("R6 reset any", int'(any), 0);
        check("R6 reset cnt", int'(cnt), 0);
        rst_n = 1'b1;
    endtask

    // All vectors under all selectors (R1, R2, R3, R8).
    task automatic t_sweep;
        for (int s = 0; s < 8; s++) begin
            for (int r = 0; r < 256; r++) begin
                apply(r, s);
                check("R3 winner", int'(idx), model_win(r, s));
                check("R1 flag", int'(any), (r != 0) ? 1 : 0);
                check("R2 count", int'(cnt), model_cnt(r));
                if (r != 0) check("R8 winner active", (r >> idx) & 1, 1);
            end
        end
    endtask

    // No request gives all-zero outputs (R5).
    task automatic t_idle;
        for (int s = 0; s < 8; s++) begin
            apply(8'hFF, s);
            apply(0, s);
            check("R5 idle idx", int'(idx), 0);
            check("R5 idle any", int'(any), 0);
            check("R5 idle cnt", int'(cnt), 0);
        end
    endtask

    // Full request vector wraps to the floor's successor (R7).
    task automatic t_full;
        for (int s = 0; s < 8; s++) begin
            apply(8'hFF, s);
            check("R7 full idx", int'(idx), (s + 1) % 8);
            check("R7 full cnt", int'(cnt), 8);
        end
    endtask

    // The floor line wins alone but loses to any other line (R4).
    task automatic t_floor;
        for (int s = 0; s < 8; s++) begin
            apply(1 << s, s);
            check("R4 floor alone", int'(idx), s);
            apply((1 << s) | (1 << ((s + 7) % 8)), s);
            check("R4 floor beaten", int'(idx), (s + 7) % 8);
        end
    endtask

    // Reset during heavy traffic clears index and count together (R6).
    task automatic t_midrun_reset;
        apply(8'hFF, 3);
        check("R6 pre-reset cnt", int'(cnt), 8);
        rst_n = 1'b0;
        @(negedge clk);
        check("R6 mid reset idx", int'(idx), 0);
        check("R6 mid reset cnt", int'(cnt), 0);
        check("R6 mid reset any", int'(any), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 resume idx", int'(idx), 4);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_idle();
        t_full();
        t_floor();
        t_midrun_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule